// File: doc/BRIEF.md
# Interrupt Request Conditioning Front-End

This block sits between the per-core external interrupt request wires of a multi-core cluster and each core's exception logic. Every request input is an active-low vector with one bit per core. All of them cross into the core clock domain through a two-flop synchroniser whose flops reset to the inactive level. Normal and fast interrupt requests, both physical and virtual, are held levels: while the legacy route is selected, the core-side outputs follow the synchronised, inverted input.

Three error classes work differently: system error, virtual system error and memory error. Each arrives as a pulse. A per-bit capture state machine with the states CAP_IDLE and CAP_PEND turns a falling edge into a sticky pending flag. The flag stays set until the core acknowledges it, however long the pulse lasted. A 2-bit cause code per core tells the core which kind of asynchronous abort to raise.

A static strap, `ctrl_bypass`, picks the source of the four interrupt outputs. When it is 1, the external legacy lines drive the core. When it is 0, the internal interrupt controller's request vectors drive the core, and the external lines have no effect on those outputs. While reset is held low, a 22-bit base address strap (address bits 39..18) is loaded into a register. That register keeps its value for as long as reset stays released.

Top module: `irq_front_cond`

## Requirements
- R1: During and right after reset, all core interrupt outputs are 0, all pending flags are 0 and every cause code is 00. A 1 on a request input means inactive, and a 0 means asserted.
- R2: With `ctrl_bypass`=1, `core_irq` and `core_fiq` equal the inverse of `req_norm_n` and `req_fast_n` as sampled two clock edges earlier.
- R3: With `ctrl_bypass`=1, `core_virq` and `core_vfiq` equal the inverse of `req_vnorm_n` and `req_vfast_n` as sampled two clock edges earlier.
- R4: With `ctrl_bypass`=0, the four core outputs equal `ctl_irq`, `ctl_fiq`, `ctl_virq` and `ctl_vfiq`. The external normal, fast and virtual request lines have no effect on them.
- R5: When an error input falls from 1 to 0 and the low level is seen by at least one clock edge, the matching pending bit is set three clock edges after the fall. The result does not depend on the pulse width.
- R6: A pending bit stays set until its acknowledge bit is high at a clock edge. It reads 0 after that edge.
- R7: If a new falling edge is detected in the same cycle as the acknowledge, the pending bit stays set (transition hold instead of release).
- R8: Bits [2c+1:2c] of `fault_cause` hold the cause for core c. The code is 2'b10 (asynchronous parity error) if memory-error is pending. Otherwise it is 2'b01 (asynchronous external abort) if system or virtual system error is pending. Otherwise it is 2'b00.
- R9: `cfg_base_q` loads `cfg_base_in` while `rst_n` is low and holds that value while `rst_n` stays high.
- R10: Each core's bits are handled independently. An event on core c changes no pending bit or cause code of another core.
- R11: Error capture, acknowledge and cause coding behave the same with either value of `ctrl_bypass`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_bypass | input | 1 | Static strap: 1 routes legacy lines to the core, 0 uses the internal controller |
| req_norm_n | input | NC | Normal interrupt requests, active low, level |
| req_fast_n | input | NC | Fast interrupt requests, active low, level |
| req_vnorm_n | input | NC | Virtual normal interrupt requests, active low, level |
| req_vfast_n | input | NC | Virtual fast interrupt requests, active low, level |
| err_sys_n | input | NC | System error requests, active low, pulsed |
| err_vsys_n | input | NC | Virtual system error requests, active low, pulsed |
| err_mem_n | input | NC | Memory error requests, active low, pulsed |
| ack_sys | input | NC | Acknowledge of system error pending bits |
| ack_vsys | input | NC | Acknowledge of virtual system error pending bits |
| ack_mem | input | NC | Acknowledge of memory error pending bits |
| ctl_irq | input | NC | Internal controller normal request, active high |
| ctl_fiq | input | NC | Internal controller fast request, active high |
| ctl_virq | input | NC | Internal controller virtual normal request, active high |
| ctl_vfiq | input | NC | Internal controller virtual fast request, active high |
| cfg_base_in | input | 22 | Base address strap, address bits 39..18 |
| core_irq | output | NC | Normal interrupt to each core, active high |
| core_fiq | output | NC | Fast interrupt to each core, active high |
| core_virq | output | NC | Virtual normal interrupt to each core, active high |
| core_vfiq | output | NC | Virtual fast interrupt to each core, active high |
| pend_sys | output | NC | System error pending flags |
| pend_vsys | output | NC | Virtual system error pending flags |
| pend_mem | output | NC | Memory error pending flags |
| fault_cause | output | 2*NC | Per-core abort cause code |
| cfg_base_q | output | 22 | Base address captured during reset |

## Verification
On every cycle, the assertions check the two-edge latency of the legacy level path, the controller path when the strap is 0, the stickiness of pending bits without acknowledge, the cause code of each core against its pending bits, and the stability of the captured base address. Some behaviours depend on a falling edge that exists only inside the synchroniser, so only the bench scenarios can show them. These are a pending bit set by a pulse of any width, clearing on acknowledge, a flag held when an edge meets an acknowledge, and the isolation between cores.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;
    typedef enum logic {
        CAP_IDLE = 1'b0,
        CAP_PEND = 1'b1
    } cap_state_e;

    localparam int unsigned ERR_CLASSES = 3;
    localparam int unsigned ERR_SYS     = 0;
    localparam int unsigned ERR_VSYS    = 1;
    localparam int unsigned ERR_MEM     = 2;

    localparam logic [1:0] CAUSE_NONE   = 2'b00;
    localparam logic [1:0] CAUSE_EXTABT = 2'b01;
    localparam logic [1:0] CAUSE_PARITY = 2'b10;
endpackage

// File: rtl/irq_sync2.sv
module irq_sync2 #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '1;
            sync_q <= '1;
        end else begin
            meta_q <= d_async;
            sync_q <= meta_q;
        end
    end

    assign q_sync = sync_q;
endmodule

// File: rtl/irq_edge_capture.sv
module irq_edge_capture
    import irq_cond_pkg::*;
#(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_n,
    input  logic [W-1:0] ack,
    output logic [W-1:0] pend
);
    cap_state_e   st_q [W];
    cap_state_e   st_d [W];
    logic [W-1:0] prev_q;
    logic [W-1:0] fall;

    assign fall = prev_q & ~lvl_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '1;
            for (int i = 0; i < int'(W); i++) st_q[i] <= CAP_IDLE;
        end else begin
            prev_q <= lvl_n;
            for (int i = 0; i < int'(W); i++) st_q[i] <= st_d[i];
        end
    end

    always_comb begin
        for (int i = 0; i < int'(W); i++) begin
            st_d[i] = st_q[i];
            unique case (st_q[i])
                CAP_IDLE: if (fall[i]) st_d[i] = CAP_PEND;
                CAP_PEND: if (ack[i] && !fall[i]) st_d[i] = CAP_IDLE;
                default:  st_d[i] = CAP_IDLE;
            endcase
        end
    end

    always_comb begin
        for (int i = 0; i < int'(W); i++) pend[i] = (st_q[i] == CAP_PEND);
    end
endmodule

// File: rtl/irq_front_cond.sv
module irq_front_cond
    import irq_cond_pkg::*;
#(
    parameter int unsigned NC     = 2,
    parameter int unsigned ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_bypass,
    input  logic [NC-1:0]     req_norm_n,
    input  logic [NC-1:0]     req_fast_n,
    input  logic [NC-1:0]     req_vnorm_n,
    input  logic [NC-1:0]     req_vfast_n,
    input  logic [NC-1:0]     err_sys_n,
    input  logic [NC-1:0]     err_vsys_n,
    input  logic [NC-1:0]     err_mem_n,
    input  logic [NC-1:0]     ack_sys,
    input  logic [NC-1:0]     ack_vsys,
    input  logic [NC-1:0]     ack_mem,
    input  logic [NC-1:0]     ctl_irq,
    input  logic [NC-1:0]     ctl_fiq,
    input  logic [NC-1:0]     ctl_virq,
    input  logic [NC-1:0]     ctl_vfiq,
    input  logic [ADDR_W-1:0] cfg_base_in,
    output logic [NC-1:0]     core_irq,
    output logic [NC-1:0]     core_fiq,
    output logic [NC-1:0]     core_virq,
    output logic [NC-1:0]     core_vfiq,
    output logic [NC-1:0]     pend_sys,
    output logic [NC-1:0]     pend_vsys,
    output logic [NC-1:0]     pend_mem,
    output logic [2*NC-1:0]   fault_cause,
    output logic [ADDR_W-1:0] cfg_base_q
);
    localparam int unsigned LVL_CLASSES = 4;
    localparam int unsigned SYNC_W      = (LVL_CLASSES + ERR_CLASSES) * NC;

    logic [SYNC_W-1:0] raw_n;
    logic [SYNC_W-1:0] syn_n;
    logic [NC-1:0]     err_lvl_n [ERR_CLASSES];
    logic [NC-1:0]     err_ack   [ERR_CLASSES];
    logic [NC-1:0]     err_pend  [ERR_CLASSES];

    assign raw_n = {err_mem_n, err_vsys_n, err_sys_n,
                    req_vfast_n, req_vnorm_n, req_fast_n, req_norm_n};

    irq_sync2 #(.W(SYNC_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_n),
        .q_sync  (syn_n)
    );

    assign err_ack[ERR_SYS]  = ack_sys;
    assign err_ack[ERR_VSYS] = ack_vsys;
    assign err_ack[ERR_MEM]  = ack_mem;

    for (genvar k = 0; k < ERR_CLASSES; k++) begin : g_err
        assign err_lvl_n[k] = syn_n[(LVL_CLASSES + k) * NC +: NC];
        irq_edge_capture #(.W(NC)) u_cap (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl_n (err_lvl_n[k]),
            .ack   (err_ack[k]),
            .pend  (err_pend[k])
        );
    end

    assign pend_sys  = err_pend[ERR_SYS];
    assign pend_vsys = err_pend[ERR_VSYS];
    assign pend_mem  = err_pend[ERR_MEM];

    for (genvar c = 0; c < NC; c++) begin : g_cause
        always_comb begin
            if (pend_mem[c])
                fault_cause[2*c +: 2] = CAUSE_PARITY;
            else if (pend_sys[c] || pend_vsys[c])
                fault_cause[2*c +: 2] = CAUSE_EXTABT;
            else
                fault_cause[2*c +: 2] = CAUSE_NONE;
        end
    end

    always_comb begin
        if (ctrl_bypass) begin
            core_irq  = ~syn_n[0*NC +: NC];
            core_fiq  = ~syn_n[1*NC +: NC];
            core_virq = ~syn_n[2*NC +: NC];
            core_vfiq = ~syn_n[3*NC +: NC];
        end else begin
            core_irq  = ctl_irq;
            core_fiq  = ctl_fiq;
            core_virq = ctl_virq;
            core_vfiq = ctl_vfiq;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_base_q <= cfg_base_in;
    end
endmodule

// File: rtl/irq_front_cond_chk.sv
module irq_front_cond_chk
    import irq_cond_pkg::*;
#(
    parameter int unsigned NC     = 2,
    parameter int unsigned ADDR_W = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctrl_bypass,
    input logic [NC-1:0]     req_norm_n,
    input logic [NC-1:0]     req_fast_n,
    input logic [NC-1:0]     req_vnorm_n,
    input logic [NC-1:0]     req_vfast_n,
    input logic [NC-1:0]     ack_sys,
    input logic [NC-1:0]     ack_vsys,
    input logic [NC-1:0]     ack_mem,
    input logic [NC-1:0]     ctl_irq,
    input logic [NC-1:0]     ctl_fiq,
    input logic [NC-1:0]     ctl_virq,
    input logic [NC-1:0]     ctl_vfiq,
    input logic [NC-1:0]     core_irq,
    input logic [NC-1:0]     core_fiq,
    input logic [NC-1:0]     core_virq,
    input logic [NC-1:0]     core_vfiq,
    input logic [NC-1:0]     pend_sys,
    input logic [NC-1:0]     pend_vsys,
    input logic [NC-1:0]     pend_mem,
    input logic [2*NC-1:0]   fault_cause,
    input logic [ADDR_W-1:0] cfg_base_q
);
    logic [1:0] run_cnt;
    logic       seen_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_cnt <= '0;
        else if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seen_rst <= 1'b1;
        else if (seen_rst !== 1'b1) seen_rst <= 1'b0;
    end

    assert_lvl_phys_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt == 2'd3 && ctrl_bypass && $past(ctrl_bypass) && $past(ctrl_bypass, 2))
        |-> (core_irq == ~$past(req_norm_n, 2) && core_fiq == ~$past(req_fast_n, 2)));

    assert_lvl_virt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt == 2'd3 && ctrl_bypass && $past(ctrl_bypass) && $past(ctrl_bypass, 2))
        |-> (core_virq == ~$past(req_vnorm_n, 2) && core_vfiq == ~$past(req_vfast_n, 2)));

    assert_ctl_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_bypass |-> (core_irq == ctl_irq && core_fiq == ctl_fiq &&
                          core_virq == ctl_virq && core_vfiq == ctl_vfiq));

    assert_base_hold_R9: assert property (@(posedge clk)
        (seen_rst === 1'b1 && rst_n && $past(rst_n)) |-> $stable(cfg_base_q));

    for (genvar c = 0; c < NC; c++) begin : g_core
        assert_pend_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ((pend_sys[c] && !ack_sys[c]) |=> pend_sys[c]) and
            ((pend_vsys[c] && !ack_vsys[c]) |=> pend_vsys[c]) and
            ((pend_mem[c] && !ack_mem[c]) |=> pend_mem[c]));

        assert_cause_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
            fault_cause[2*c +: 2] ==
                (pend_mem[c] ? CAUSE_PARITY :
                 ((pend_sys[c] || pend_vsys[c]) ? CAUSE_EXTABT : CAUSE_NONE)));

        assert_reset_clear_R1: assert property (@(posedge clk)
            !rst_n |=> (!pend_sys[c] && !pend_vsys[c] && !pend_mem[c]));
    end
endmodule

bind irq_front_cond irq_front_cond_chk #(.NC(NC), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_bypass (ctrl_bypass),
    .req_norm_n  (req_norm_n),
    .req_fast_n  (req_fast_n),
    .req_vnorm_n (req_vnorm_n),
    .req_vfast_n (req_vfast_n),
    .ack_sys     (ack_sys),
    .ack_vsys    (ack_vsys),
    .ack_mem     (ack_mem),
    .ctl_irq     (ctl_irq),
    .ctl_fiq     (ctl_fiq),
    .ctl_virq    (ctl_virq),
    .ctl_vfiq    (ctl_vfiq),
    .core_irq    (core_irq),
    .core_fiq    (core_fiq),
    .core_virq   (core_virq),
    .core_vfiq   (core_vfiq),
    .pend_sys    (pend_sys),
    .pend_vsys   (pend_vsys),
    .pend_mem    (pend_mem),
    .fault_cause (fault_cause),
    .cfg_base_q  (cfg_base_q)
);

// File: tb/irq_front_cond_tb.sv
module irq_front_cond_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctrl_bypass = 1'b1;
    logic [NC-1:0] req_norm_n = '1, req_fast_n = '1, req_vnorm_n = '1, req_vfast_n = '1;
    logic [NC-1:0] err_sys_n = '1, err_vsys_n = '1, err_mem_n = '1;
    logic [NC-1:0] ack_sys = '0, ack_vsys = '0, ack_mem = '0;
    logic [NC-1:0] ctl_irq = '0, ctl_fiq = '0, ctl_virq = '0, ctl_vfiq = '0;
    logic [21:0]   cfg_base_in = 22'h2A5C3;
    logic [NC-1:0] core_irq, core_fiq, core_virq, core_vfiq;
    logic [NC-1:0] pend_sys, pend_vsys, pend_mem;
    logic [2*NC-1:0] fault_cause;
    logic [21:0]   cfg_base_q;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_front_cond #(.NC(NC)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_bypass(ctrl_bypass),
        .req_norm_n(req_norm_n), .req_fast_n(req_fast_n),
        .req_vnorm_n(req_vnorm_n), .req_vfast_n(req_vfast_n),
        .err_sys_n(err_sys_n), .err_vsys_n(err_vsys_n), .err_mem_n(err_mem_n),
        .ack_sys(ack_sys), .ack_vsys(ack_vsys), .ack_mem(ack_mem),
        .ctl_irq(ctl_irq), .ctl_fiq(ctl_fiq), .ctl_virq(ctl_virq), .ctl_vfiq(ctl_vfiq),
        .cfg_base_in(cfg_base_in),
        .core_irq(core_irq), .core_fiq(core_fiq), .core_virq(core_virq), .core_vfiq(core_vfiq),
        .pend_sys(pend_sys), .pend_vsys(pend_vsys), .pend_mem(pend_mem),
        .fault_cause(fault_cause), .cfg_base_q(cfg_base_q)
    );

    // {bypass, ext_n[norm,fast,vnorm,vfast], ctl[irq,fiq,virq,vfiq], expected core outputs}
    localparam logic [12:0] LVL_TBL [9] = '{
        13'b1_0111_1111_1000,  // R2 normal level, ctl ignored
        13'b1_1011_0000_0100,  // R2 fast level
        13'b1_1101_0000_0010,  // R3 virtual normal
        13'b1_1110_0000_0001,  // R3 virtual fast
        13'b1_0000_0000_1111,  // R2 R3 all asserted
        13'b1_1111_1111_0000,  // R2 nothing asserted
        13'b0_0000_0000_0000,  // R4 external lines ignored
        13'b0_1111_1010_1010,  // R4 controller drives
        13'b0_0101_0110_0110   // R4 mixed
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_err(input int cls, input int core, input logic v);
        case (cls)
            0:       err_sys_n[core]  = v;
            1:       err_vsys_n[core] = v;
            default: err_mem_n[core]  = v;
        endcase
    endtask

    task automatic set_ack(input int cls, input int core, input logic v);
        case (cls)
            0:       ack_sys[core]  = v;
            1:       ack_vsys[core] = v;
            default: ack_mem[core]  = v;
        endcase
    endtask

    function automatic logic [NC-1:0] pend_of(input int cls);
        case (cls)
            0:       return pend_sys;
            1:       return pend_vsys;
            default: return pend_mem;
        endcase
    endfunction

    task automatic pulse(input int cls, input int core, input int w);
        set_err(cls, core, 1'b0);
        tick(w);
        set_err(cls, core, 1'b1);
    endtask

    task automatic ack_one(input int cls, input int core);
        set_ack(cls, core, 1'b1);
        tick(1);
        set_ack(cls, core, 1'b0);
    endtask

    initial begin
        tick(4);
        check("R1 reset core outputs", {core_irq, core_fiq, core_virq, core_vfiq}, '0);
        check("R1 reset pending", {pend_sys, pend_vsys, pend_mem}, '0);
        check("R1 reset cause", fault_cause, '0);
        check("R9 base captured in reset", cfg_base_q, 22'h2A5C3);
        rst_n = 1'b1;
        cfg_base_in = 22'h15A3C;
        tick(3);
        check("R9 base held after reset", cfg_base_q, 22'h2A5C3);
        check("R1 no request after reset", {core_irq, core_fiq, core_virq, core_vfiq}, '0);

        for (int e = 0; e < 9; e++) begin
            logic [12:0] v;
            v = LVL_TBL[e];
            ctrl_bypass = v[12];
            req_norm_n  = {NC{v[11]}};
            req_fast_n  = {NC{v[10]}};
            req_vnorm_n = {NC{v[9]}};
            req_vfast_n = {NC{v[8]}};
            ctl_irq  = {NC{v[7]}};
            ctl_fiq  = {NC{v[6]}};
            ctl_virq = {NC{v[5]}};
            ctl_vfiq = {NC{v[4]}};
            tick(3);
            check(v[12] ? "R2 R3 legacy level path" : "R4 controller path",
                  {core_irq, core_fiq, core_virq, core_vfiq},
                  {{NC{v[3]}}, {NC{v[2]}}, {NC{v[1]}}, {NC{v[0]}}});
        end
        req_norm_n = '1; req_fast_n = '1; req_vnorm_n = '1; req_vfast_n = '1;
        ctl_irq = '0; ctl_fiq = '0; ctl_virq = '0; ctl_vfiq = '0;
        ctrl_bypass = 1'b1;
        tick(3);

        // R5 R6 R8 R10 R11: random classes, cores and pulse widths, both strap values
        for (int it = 0; it < 24; it++) begin
            int cls, core, w, other;
            cls  = int'($urandom % 3);
            core = int'($urandom % NC);
            w    = 1 + int'($urandom % 6);
            other = (core + 1) % NC;
            ctrl_bypass = it[0];
            pulse(cls, core, w);
            tick(3);
            check("R5 R11 pending after pulse", pend_of(cls), NC'(1) << core);
            check("R10 other classes untouched",
                  {pend_sys, pend_vsys, pend_mem} & ~({NC'(0), NC'(0), NC'(0)} | {pend_of(cls) & {NC{cls == 0}}, pend_of(cls) & {NC{cls == 1}}, pend_of(cls) & {NC{cls == 2}}}), '0);
            check("R8 cause of hit core", fault_cause[2*core +: 2], (cls == 2) ? 2'b10 : 2'b01);
            check("R10 cause of other core", fault_cause[2*other +: 2], 2'b00);
            tick(w + 4);
            check("R6 pending held without ack", pend_of(cls), NC'(1) << core);
            ack_one(cls, core);
            check("R6 pending cleared by ack", pend_of(cls), '0);
            check("R6 cause cleared", fault_cause, '0);
        end
        ctrl_bypass = 1'b1;

        // R8 priority: memory error outranks system error
        pulse(0, 0, 2);
        pulse(2, 0, 3);
        tick(3);
        check("R8 parity wins over external abort", fault_cause[1:0], 2'b10);
        ack_one(2, 0);
        check("R8 external abort after parity ack", fault_cause[1:0], 2'b01);
        ack_one(0, 0);
        check("R8 none after both acks", fault_cause[1:0], 2'b00);

        // R7: new edge seen in the same cycle as the acknowledge keeps the flag
        pulse(1, 1, 2);
        tick(3);
        check("R7 setup pending", pend_vsys, 2'b10);
        set_err(1, 1, 1'b0);
        tick(2);
        set_ack(1, 1, 1'b1);
        tick(1);
        set_ack(1, 1, 1'b0);
        check("R7 edge with ack keeps pending", pend_vsys, 2'b10);
        set_err(1, 1, 1'b1);
        tick(3);
        ack_one(1, 1);
        check("R7 later ack clears", pend_vsys, 2'b00);

        // R5: a long held low level gives exactly one event
        set_err(0, 1, 1'b0);
        tick(6);
        ack_one(0, 1);
        tick(4);
        check("R5 held low does not re-arm", pend_sys, 2'b00);
        set_err(0, 1, 1'b1);
        tick(3);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule